// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host port and an external 128K x 8 asynchronous static RAM. The host issues single-byte reads and writes through a valid/ready handshake. The controller turns each request into a strobe sequence on the memory side. That side has two chip enables of opposite polarity (one active low, one active high), an active-low write enable and an active-low output enable. A single down-counter stretches every phase to meet the memory's minimum timings. Each phase length is computed from a nanosecond minimum and the clock period by ceiling division.

The shared data bus is presented as separate outbound data, inbound data and a drive-enable, for a pad cell outside the block. The controller releases its drive whenever the memory may be driving. When the transfer direction changes, it inserts a bus turnaround gap long enough for the memory's output to float.

A retention request puts the memory into a deselected low-power state. After the request is withdrawn and the host reports stable power, the controller keeps the memory deselected for a long recovery wait before it accepts any access.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and whenever no access is in progress, the memory is deselected: `sram_ce1_n`=1, `sram_ce2`=0, `sram_we_n`=1, `sram_oe_n`=1 and `sram_dq_oe`=0.
- R2: A read holds `sram_ce1_n`=0, `sram_ce2`=1, `sram_we_n`=1 and `sram_oe_n`=0 for exactly ceil(T_RC_NS/CLK_NS) cycles. The address is held stable and the bus is not driven.
- R3: The read byte is sampled from `sram_dq_in` at the clock edge that ends the read window. It is presented on `rsp_rdata`, with `rsp_valid` high for exactly one cycle, in the cycle after that edge.
- R4: A write holds both enables active with `sram_we_n`=0 for ceil(max(T_WP_NS,T_CW_NS)/CLK_NS) cycles. It then holds `sram_we_n`=1 with the enables still active for the rest of ceil(T_WC_NS/CLK_NS) cycles, and at least one cycle. `sram_oe_n` stays 1 throughout, and `sram_dq_oe`=1 with the request's data and address on the bus for the whole write.
- R5: When an access runs in the opposite direction to the previous one, ceil(T_HZ_NS/CLK_NS) deselected, undriven cycles precede it. Two accesses in the same direction, and the first access after reset, have no gap.
- R6: `req_ready` is high only when the controller is idle and `ret_req` is low. A request is taken exactly when `req_valid` and `req_ready` are both high at a clock edge.
- R7: `ret_req` high while idle moves the controller into retention. The memory stays deselected and `req_ready` stays low until `ret_req` is low and `pwr_stable` is high at the same edge.
- R8: On leaving retention, the memory stays deselected with `req_ready` low for ceil(T_RECOV_NS/CLK_NS) more cycles, after which the controller is idle.
- R9: The controller never drives the bus while `sram_oe_n` is low.
- R10: `sram_we_n` and `sram_oe_n` are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read data |
| ret_req | input | 1 | Enter and hold retention |
| pwr_stable | input | 1 | Supply restored, retention may end |
| sram_addr | output | 17 | Memory address |
| sram_ce1_n | output | 1 | Chip enable, active low |
| sram_ce2 | output | 1 | Chip enable, active high |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_dq_out | output | 8 | Data toward the memory |
| sram_dq_oe | output | 1 | Drive enable for the data pads |
| sram_dq_in | input | 8 | Data from the memory |

## Verification
The bench builds the block with a 5 ns period and the default memory timings. Reads therefore last 17 cycles, a write has a 15-cycle low pulse and a 2-cycle tail, and the turnaround gap is 7 cycles. Recovery is shortened to 300 ns (60 cycles), so the complete retention entry, the stall on power and the exit with its recovery wait fit in a short run. A request is held pending across the whole retention episode and is accepted only after recovery. The bench's memory model drives filler data outside the read window, so a capture at any edge other than the last one of the window shows up as wrong data.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_READ,
        ST_WLOW,
        ST_WTAIL,
        ST_RET,
        ST_RECOV
    } ctrl_state_e;

    typedef enum logic [1:0] {
        DIR_NONE,
        DIR_READ,
        DIR_WRITE
    } xfer_dir_e;

    typedef struct packed {
        logic ce1_n;
        logic ce2;
        logic we_n;
        logic oe_n;
        logic drive;
    } strobe_t;

    function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
        int unsigned c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max_u(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobe_t strobe_for(ctrl_state_e s);
        strobe_t r;
        r.ce1_n = 1'b1;
        r.ce2   = 1'b0;
        r.we_n  = 1'b1;
        r.oe_n  = 1'b1;
        r.drive = 1'b0;
        case (s)
            ST_READ: begin
                r.ce1_n = 1'b0; r.ce2 = 1'b1; r.oe_n = 1'b0;
            end
            ST_WLOW: begin
                r.ce1_n = 1'b0; r.ce2 = 1'b1; r.we_n = 1'b0; r.drive = 1'b1;
            end
            ST_WTAIL: begin
                r.ce1_n = 1'b0; r.ce2 = 1'b1; r.drive = 1'b1;
            end
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_data_path.sv
module sram_data_path #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] sram_dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              is_write_q,
    output logic              rsp_valid_q,
    output logic [DATA_W-1:0] rdata_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q      <= '0;
            wdata_q     <= '0;
            is_write_q  <= 1'b0;
            rsp_valid_q <= 1'b0;
            rdata_q     <= '0;
        end else begin
            if (accept) begin
                addr_q     <= req_addr;
                wdata_q    <= req_wdata;
                is_write_q <= req_write;
            end
            if (cap_en) rdata_q <= sram_dq_in;
            rsp_valid_q <= cap_en;
        end
    end

    // R3: a response pulse lasts one cycle only
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_q |=> !rsp_valid_q);
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int DATA_W     = 8,
    parameter int CLK_NS     = 5,
    parameter int T_RC_NS    = 85,
    parameter int T_WC_NS    = 85,
    parameter int T_WP_NS    = 60,
    parameter int T_CW_NS    = 75,
    parameter int T_HZ_NS    = 35,
    parameter int T_RECOV_NS = 5000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              ret_req,
    input  logic              pwr_stable,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce1_n,
    output logic              sram_ce2,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic [DATA_W-1:0] sram_dq_out,
    output logic              sram_dq_oe,
    input  logic [DATA_W-1:0] sram_dq_in
);
    localparam int unsigned READ_C  = ns_to_cyc(T_RC_NS, CLK_NS);
    localparam int unsigned WLOW_C  = ns_to_cyc(max_u(T_WP_NS, T_CW_NS), CLK_NS);
    localparam int unsigned WC_C    = ns_to_cyc(T_WC_NS, CLK_NS);
    localparam int unsigned WTAIL_C = (WC_C > WLOW_C) ? (WC_C - WLOW_C) : 1;
    localparam int unsigned TURN_C  = ns_to_cyc(T_HZ_NS, CLK_NS);
    localparam int unsigned RECOV_C = ns_to_cyc(T_RECOV_NS, CLK_NS);
    localparam int unsigned MAX_C   = max_u(max_u(READ_C, WLOW_C),
                                            max_u(max_u(WTAIL_C, TURN_C), RECOV_C));
    localparam int CNT_W = $clog2(MAX_C + 1);

    ctrl_state_e      state_q, state_d;
    xfer_dir_e        dir_q, op_dir;
    strobe_t          strb_q;
    logic             accept, t_load, t_done, cap_en, is_write_q;
    logic [CNT_W-1:0] t_val;

    assign req_ready = (state_q == ST_IDLE) && !ret_req;
    assign accept    = req_valid && req_ready;
    assign op_dir    = req_write ? DIR_WRITE : DIR_READ;
    assign cap_en    = (state_q == ST_READ) && t_done;

    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_val   = '0;
        case (state_q)
            ST_IDLE: begin
                if (ret_req) begin
                    state_d = ST_RET;
                end else if (accept) begin
                    t_load = 1'b1;
                    if (dir_q != DIR_NONE && dir_q != op_dir) begin
                        state_d = ST_TURN;  t_val = CNT_W'(TURN_C - 1);
                    end else if (req_write) begin
                        state_d = ST_WLOW;  t_val = CNT_W'(WLOW_C - 1);
                    end else begin
                        state_d = ST_READ;  t_val = CNT_W'(READ_C - 1);
                    end
                end
            end
            ST_TURN: if (t_done) begin
                t_load = 1'b1;
                if (is_write_q) begin
                    state_d = ST_WLOW;  t_val = CNT_W'(WLOW_C - 1);
                end else begin
                    state_d = ST_READ;  t_val = CNT_W'(READ_C - 1);
                end
            end
            ST_READ:  if (t_done) state_d = ST_IDLE;
            ST_WLOW:  if (t_done) begin
                state_d = ST_WTAIL; t_load = 1'b1; t_val = CNT_W'(WTAIL_C - 1);
            end
            ST_WTAIL: if (t_done) state_d = ST_IDLE;
            ST_RET:   if (!ret_req && pwr_stable) begin
                state_d = ST_RECOV; t_load = 1'b1; t_val = CNT_W'(RECOV_C - 1);
            end
            ST_RECOV: if (t_done) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            dir_q   <= DIR_NONE;
            strb_q  <= strobe_for(ST_IDLE);
        end else begin
            state_q <= state_d;
            strb_q  <= strobe_for(state_d);
            if (accept) dir_q <= op_dir;
        end
    end

    sram_wait_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .done(t_done)
    );

    sram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
        .clk(clk), .rst(rst), .accept(accept), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cap_en(cap_en),
        .sram_dq_in(sram_dq_in), .addr_q(sram_addr), .wdata_q(sram_dq_out),
        .is_write_q(is_write_q), .rsp_valid_q(rsp_valid), .rdata_q(rsp_rdata)
    );

    assign sram_ce1_n = strb_q.ce1_n;
    assign sram_ce2   = strb_q.ce2;
    assign sram_we_n  = strb_q.we_n;
    assign sram_oe_n  = strb_q.oe_n;
    assign sram_dq_oe = strb_q.drive;

    // R9: no drive while the memory output is enabled
    a_r9_no_contention: assert property (@(posedge clk) disable iff (rst)
        !(sram_dq_oe && !sram_oe_n));
    // R10: write and output enables are exclusive
    a_r10_we_oe_excl: assert property (@(posedge clk) disable iff (rst)
        !(!sram_we_n && !sram_oe_n));
    // R6: accepting only while the memory is deselected and undriven
    a_r6_ready_idle: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (sram_ce1_n && !sram_ce2 && !sram_dq_oe));
    // R2: address held while the output stays enabled
    a_r2_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!sram_oe_n && $past(!sram_oe_n)) |-> $stable(sram_addr));
    // R4: driving only inside an active, non-reading write
    a_r4_drive_in_write: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> (!sram_ce1_n && sram_ce2 && sram_oe_n));
    // R7: retention request leaves the controller not ready
    a_r7_ret_not_ready: assert property (@(posedge clk) disable iff (rst)
        ret_req |-> !req_ready);
endmodule

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb_top;
    localparam int CLK_NS = 5;
    localparam int RECOV_NS = 300;

    function automatic int cdiv(int a, int b);
        return (a + b - 1) / b;
    endfunction

    localparam int RD_C  = cdiv(85, CLK_NS);
    localparam int WL_C  = cdiv(75, CLK_NS);
    localparam int WT_C  = cdiv(85, CLK_NS) - cdiv(75, CLK_NS);
    localparam int TN_C  = cdiv(35, CLK_NS);
    localparam int RC_C  = cdiv(RECOV_NS, CLK_NS);

    logic clk = 1'b0, rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, ret_req = 1'b0, pwr_stable = 1'b0;
    logic [16:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic req_ready, rsp_valid, ce1_n, ce2, we_n, oe_n, dq_oe;
    logic [7:0] rsp_rdata, dq_out, dq_in;
    logic [16:0] sram_addr;

    always #2.5 clk = ~clk;

    sram_async_ctrl #(.CLK_NS(CLK_NS), .T_RECOV_NS(RECOV_NS)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ret_req(ret_req),
        .pwr_stable(pwr_stable), .sram_addr(sram_addr), .sram_ce1_n(ce1_n),
        .sram_ce2(ce2), .sram_we_n(we_n), .sram_oe_n(oe_n),
        .sram_dq_out(dq_out), .sram_dq_oe(dq_oe), .sram_dq_in(dq_in)
    );

    // memory device model
    logic [7:0] dev_mem [int];
    function automatic logic [7:0] fill(int a);
        return a[7:0] ^ 8'hA5;
    endfunction
    always @(posedge we_n)
        if (ce1_n === 1'b0 && ce2 === 1'b1) dev_mem[int'(sram_addr)] = dq_out;
    always @(ce1_n, ce2, we_n, oe_n, sram_addr) begin
        if (!ce1_n && ce2 && we_n && !oe_n)
            dq_in = dev_mem.exists(int'(sram_addr)) ? dev_mem[int'(sram_addr)] : fill(int'(sram_addr));
        else
            dq_in = 8'hEE;
    end

    // reference model
    typedef struct {
        logic [4:0] strb;   // {ce1_n, ce2, we_n, oe_n, drive}
        bit rdy_live;
        bit rsp;
        int addr;
        int data;
        int tag;
    } exp_t;

    exp_t exp_q[$];
    logic [7:0] rd_q[$];
    logic [7:0] shadow [int];
    int last_dir = 0;   // 0 none, 1 read, 2 write
    bit in_ret = 0;
    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;

    localparam logic [4:0] S_OFF = 5'b10110;
    localparam logic [4:0] S_RD  = 5'b01100;
    localparam logic [4:0] S_WL  = 5'b01011;
    localparam logic [4:0] S_WT  = 5'b01111;

    function automatic string tname(int t);
        case (t)
            1: return "R1"; 2: return "R2"; 3: return "R3"; 4: return "R4";
            5: return "R5"; 6: return "R6"; 7: return "R7"; 8: return "R8";
            9: return "R9"; default: return "R10";
        endcase
    endfunction

    task automatic chk(bit ok, int t, string what, int got, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s got %0h expected %0h (cycle %0d)", tname(t), what, got, expv, cyc);
        end
    endtask

    function automatic exp_t mk(logic [4:0] s, int a, int d, int t);
        exp_t e;
        e.strb = s; e.rdy_live = 0; e.rsp = 0; e.addr = a; e.data = d; e.tag = t;
        return e;
    endfunction

    task automatic push_op(bit wr, int a, int d);
        int dir = wr ? 2 : 1;
        exp_t e;
        if (last_dir != 0 && last_dir != dir)
            for (int i = 0; i < TN_C; i++) exp_q.push_back(mk(S_OFF, -1, -1, 5));
        if (wr) begin
            for (int i = 0; i < WL_C; i++) exp_q.push_back(mk(S_WL, a, d, 4));
            for (int i = 0; i < WT_C; i++) exp_q.push_back(mk(S_WT, a, d, 4));
            shadow[a] = d[7:0];
        end else begin
            for (int i = 0; i < RD_C; i++) exp_q.push_back(mk(S_RD, a, -1, 2));
            e = mk(S_OFF, -1, -1, 3);
            e.rdy_live = 1; e.rsp = 1;
            exp_q.push_back(e);
            rd_q.push_back(shadow.exists(a) ? shadow[a] : fill(a));
        end
        last_dir = dir;
    endtask

    always @(negedge clk) begin
        exp_t e;
        logic exp_rdy;
        logic [7:0] er;
        cyc++;
        if (!rst && !finished) begin
            if (exp_q.size() > 0) e = exp_q.pop_front();
            else begin
                e = mk(S_OFF, -1, -1, in_ret ? 7 : 1);
                e.rdy_live = 1;
            end
            exp_rdy = e.rdy_live ? (!in_ret && !ret_req) : 1'b0;
            chk({ce1_n, ce2, we_n, oe_n, dq_oe} === e.strb, e.tag, "strobes",
                int'({ce1_n, ce2, we_n, oe_n, dq_oe}), int'(e.strb));
            chk(req_ready === exp_rdy, in_ret ? 7 : 6, "ready", int'(req_ready), int'(exp_rdy));
            if (e.addr >= 0) chk(int'(sram_addr) == e.addr, e.tag, "addr", int'(sram_addr), e.addr);
            if (e.data >= 0) chk(int'(dq_out) == e.data, 4, "wdata", int'(dq_out), e.data);
            chk(rsp_valid === e.rsp, 3, "rsp_valid", int'(rsp_valid), int'(e.rsp));
            if (e.rsp) begin
                er = rd_q.pop_front();
                chk(rsp_rdata === er, 3, "rdata", int'(rsp_rdata), int'(er));
            end
            // R9 and R10 on every cycle
            chk(!(dq_oe && !oe_n), 9, "drive with oe", int'(dq_oe), 0);
            chk(!(!we_n && !oe_n), 10, "we and oe low", int'(we_n), 1);
            // model transitions
            if (in_ret) begin
                if (!ret_req && pwr_stable) begin
                    for (int i = 0; i < RC_C; i++) exp_q.push_back(mk(S_OFF, -1, -1, 8));
                    in_ret = 0;
                end
            end else if (e.rdy_live) begin
                if (ret_req) in_ret = 1;
                else if (req_valid) push_op(req_write, int'(req_addr), int'(req_wdata));
            end
        end
    end

    task automatic do_req(bit wr, int a, int d);
        bit acc;
        req_valid = 1'b1; req_write = wr; req_addr = a[16:0]; req_wdata = d[7:0];
        forever begin
            @(negedge clk); acc = req_ready;
            @(posedge clk); #1;
            if (acc) break;
        end
        req_valid = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R1: reset state, checked while still in reset
        chk({ce1_n, ce2, we_n, oe_n, dq_oe} === S_OFF, 1, "reset strobes",
            int'({ce1_n, ce2, we_n, oe_n, dq_oe}), int'(S_OFF));
        rst = 1'b0;
        @(posedge clk); #1;
        do_req(1'b1, 'h00010, 'h3C);     // R4 first write, no gap
        do_req(1'b1, 'h1FFFF, 'hFF);     // R4 same direction, top address
        do_req(1'b0, 'h00010, 0);        // R5 turnaround then R2 read
        do_req(1'b0, 'h1FFFF, 0);        // back-to-back reads
        do_req(1'b0, 'h00000, 0);        // never-written location
        do_req(1'b1, 'h00000, 'h81);     // R5 read to write
        do_req(1'b0, 'h00000, 0);        // R5 write to read
        repeat (30) @(posedge clk); #1;
        // R7: retention with a request pending
        req_valid = 1'b1; req_write = 1'b1; req_addr = 'h0ABCD; req_wdata = 'h5E;
        ret_req = 1'b1;
        repeat (20) @(posedge clk); #1;
        ret_req = 1'b0;                  // power not yet stable: stay
        repeat (15) @(posedge clk); #1;
        pwr_stable = 1'b1;               // R8 recovery begins
        do_req(1'b1, 'h0ABCD, 'h5E);
        do_req(1'b0, 'h0ABCD, 0);
        repeat (40) @(posedge clk); #1;
        finish_run();
    end
endmodule